// File: doc/BRIEF.md
# Link Command Slot Target Filter

This block sits on the codec side of a serial audio link, behind the deserializer. Each received frame is handed to it in parallel: the 16-bit tag word, command address slot 1 and command data slot 2, together with a one-cycle frame strobe. The block decides whether the frame carries a register access addressed to this codec. If it does, the block emits a single read or write strobe with the register index and the write data. Any other frame is dropped without effect.

A strap input sets whether the device answers as the primary or the secondary codec on a shared output line. The two use different addressing. The primary follows the slot-valid tag bits. The secondary answers only when those bits are clear and the two-bit codec ID field in the tag selects it. The primary therefore ignores accesses meant for the secondary, even though the slots carry the same layout.

Top module: `cmd_slot_filter`

## Requirements
- R1: A frame is acted on only when `frame_stb_i` is high and tag bit 15 (frame valid) is 1; otherwise no strobe follows.
- R2: Strapped primary (`secondary_i`=0), a frame with tag bit 14 set and codec ID (tag bits 1:0) of 00 or 01 is accepted. It is a write if tag bit 13 is also set and a read otherwise; tag bits 12:2 are ignored.
- R3: Strapped primary, a frame with tag bit 14 clear gives no strobe, whatever tag bit 13 and the slot contents are.
- R4: Strapped primary, a frame with tag bits 14 and 13 set is dropped as malformed when slot 1 bit 19 is 1 (1 = read, 0 = write).
- R5: Strapped secondary (`secondary_i`=1), a frame with tag bits 14:13 = 00 and codec ID 01 is accepted. Slot 1 bit 19 = 1 gives a read and 0 gives a write.
- R6: Strapped secondary, a frame with tag bit 14 or tag bit 13 set gives no strobe.
- R7: Codec IDs 10 and 11 give no strobe for either strap, and codec ID 00 never gives a strobe to the secondary.
- R8: On an accepted access, `reg_idx_o` is slot 1 bits 18:12. On an accepted write, `wr_data_o` is slot 2 bits 19:4.
- R9: Each accepted frame gives exactly one strobe, one cycle wide, in the cycle after the frame strobe. `rd_stb_o` and `wr_stb_o` are never high together, and frames on consecutive cycles give strobes on consecutive cycles.
- R10: While `rst_ni` is low, both strobes and `reg_idx_o` and `wr_data_o` are 0.
- R11: `reg_idx_o` holds its value until the next accepted access. `wr_data_o` holds its value until the next accepted write, so a read leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| secondary_i | input | 1 | Strap: 0 primary codec, 1 secondary codec |
| frame_stb_i | input | 1 | One-cycle strobe marking a received frame |
| tag_i | input | 16 | Tag slot word of the frame |
| slot1_i | input | 20 | Command address slot |
| slot2_i | input | 20 | Command data slot |
| rd_stb_o | output | 1 | Register read strobe |
| wr_stb_o | output | 1 | Register write strobe |
| reg_idx_o | output | 7 | Register index of the last accepted access |
| wr_data_o | output | 16 | Write data of the last accepted write |

## Verification
The hardest cases are frames that look almost valid. Examples are a primary write whose direction bit says read, a secondary frame with only one slot-valid bit set, and codec IDs 00, 10 and 11 under each strap. The only sign that such a frame was dropped is a strobe that never appears and index and data outputs that keep their old values. The vector table therefore places each near-miss right after an accepted access with distinctive index and data. A check that the outputs still hold those values then shows that the dropped frame left no trace. Back-to-back frames and a reset in the middle of the run are driven separately.

// File: rtl/cmd_filter_pkg.sv
package cmd_filter_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/slot_fields.sv
module slot_fields #(
  parameter int SLOT_W = 20,
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic [SLOT_W-1:0] slot1_i,
  input  logic [SLOT_W-1:0] slot2_i,
  output logic              dir_read_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int DIR_BIT  = SLOT_W - 1;
  localparam int IDX_LSB  = DIR_BIT - IDX_W;
  localparam int DATA_LSB = SLOT_W - DATA_W;

  assign dir_read_o = slot1_i[DIR_BIT];
  assign idx_o      = slot1_i[DIR_BIT-1:IDX_LSB];
  assign data_o     = slot2_i[SLOT_W-1:DATA_LSB];
endmodule

// File: rtl/tag_classify.sv
module tag_classify
  import cmd_filter_pkg::*;
#(
  parameter int             TAG_W  = 16,
  parameter int             ID_W   = 2,
  parameter logic [ID_W-1:0] SEC_ID = 2'b01
) (
  input  logic [TAG_W-1:0] tag_i,
  input  logic             dir_read_i,
  input  logic             secondary_i,
  output acc_kind_e        kind_o
);
  localparam int FV_BIT  = TAG_W - 1;
  localparam int AV_BIT  = TAG_W - 2;
  localparam int DV_BIT  = TAG_W - 3;

  logic            frame_ok, addr_v, data_v;
  logic [ID_W-1:0] id;
  acc_kind_e       prim_kind, sec_kind;

  assign frame_ok = tag_i[FV_BIT];
  assign addr_v   = tag_i[AV_BIT];
  assign data_v   = tag_i[DV_BIT];
  assign id       = tag_i[ID_W-1:0];

  // primary: slot-valid tags rule; only the top ID bit excludes it
  always_comb begin
    prim_kind = ACC_NONE;
    if (frame_ok && addr_v && !id[ID_W-1]) begin
      if (data_v) prim_kind = dir_read_i ? ACC_NONE : ACC_WRITE;
      else        prim_kind = ACC_READ;
    end
  end

  // secondary: tags clear, ID must match
  always_comb begin
    sec_kind = ACC_NONE;
    if (frame_ok && !addr_v && !data_v && (id == SEC_ID))
      sec_kind = dir_read_i ? ACC_READ : ACC_WRITE;
  end

  assign kind_o = secondary_i ? sec_kind : prim_kind;
endmodule

// File: rtl/strobe_out.sv
module strobe_out
  import cmd_filter_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  acc_kind_e         kind_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] data_o
);
  logic take_rd, take_wr;

  assign take_rd = stb_i && (kind_i == ACC_READ);
  assign take_wr = stb_i && (kind_i == ACC_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_stb_o <= 1'b0;
      wr_stb_o <= 1'b0;
    end else begin
      rd_stb_o <= take_rd;
      wr_stb_o <= take_wr;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                idx_o <= '0;
    else if (take_rd || take_wr) idx_o <= idx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_o <= '0;
    else if (take_wr) data_o <= data_i;
  end

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_o && wr_stb_o));
  p_needs_stb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o || wr_stb_o) |-> $past(stb_i));
  p_idx_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_o || wr_stb_o) |-> $stable(idx_o));
  p_data_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_o |-> $stable(data_o));
endmodule

// File: rtl/cmd_slot_filter.sv
module cmd_slot_filter
  import cmd_filter_pkg::*;
#(
  parameter int              TAG_W  = 16,
  parameter int              SLOT_W = 20,
  parameter int              IDX_W  = 7,
  parameter int              DATA_W = 16,
  parameter int              ID_W   = 2,
  parameter logic [ID_W-1:0] SEC_ID = 2'b01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              secondary_i,
  input  logic              frame_stb_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [SLOT_W-1:0] slot1_i,
  input  logic [SLOT_W-1:0] slot2_i,
  output logic              rd_stb_o,
  output logic              wr_stb_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int FV_BIT   = TAG_W - 1;
  localparam int AV_BIT   = TAG_W - 2;
  localparam int DV_BIT   = TAG_W - 3;
  localparam int DIR_BIT  = SLOT_W - 1;
  localparam int DATA_LSB = SLOT_W - DATA_W;

  logic              dir_read;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] data;
  acc_kind_e         kind;

  slot_fields #(.SLOT_W(SLOT_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fields (
    .slot1_i    (slot1_i),
    .slot2_i    (slot2_i),
    .dir_read_o (dir_read),
    .idx_o      (idx),
    .data_o     (data)
  );

  tag_classify #(.TAG_W(TAG_W), .ID_W(ID_W), .SEC_ID(SEC_ID)) u_classify (
    .tag_i       (tag_i),
    .dir_read_i  (dir_read),
    .secondary_i (secondary_i),
    .kind_o      (kind)
  );

  strobe_out #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (frame_stb_i),
    .kind_i   (kind),
    .idx_i    (idx),
    .data_i   (data),
    .rd_stb_o (rd_stb_o),
    .wr_stb_o (wr_stb_o),
    .idx_o    (reg_idx_o),
    .data_o   (wr_data_o)
  );

  p_frame_valid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o || wr_stb_o) |-> $past(tag_i[FV_BIT]));
  p_prim_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_stb_o || wr_stb_o) && !$past(secondary_i)) |-> $past(tag_i[AV_BIT]));
  p_prim_dir_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stb_o && !$past(secondary_i)) |-> !$past(slot1_i[DIR_BIT]));
  p_sec_tags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_stb_o || wr_stb_o) && $past(secondary_i))
      |-> !$past(tag_i[AV_BIT]) && !$past(tag_i[DV_BIT]));
  p_id_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_o || wr_stb_o) |-> !$past(tag_i[ID_W-1]));
  p_wdata_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb_o |-> (wr_data_o == $past(slot2_i[SLOT_W-1:DATA_LSB])));
endmodule

// File: tb/cmd_slot_filter_tb_top.sv
module cmd_slot_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec = 1'b0;
  logic        stb = 1'b0;
  logic [15:0] tag = '0;
  logic [19:0] s1 = '0;
  logic [19:0] s2 = '0;
  logic        rd_stb, wr_stb;
  logic [6:0]  idx_o;
  logic [15:0] data_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic [6:0]  m_idx = '0;
  logic [15:0] m_data = '0;

  always #4 clk = ~clk;  // 125 MHz

  cmd_slot_filter dut_i (
    .clk_i(clk), .rst_ni(rst_n), .secondary_i(sec), .frame_stb_i(stb),
    .tag_i(tag), .slot1_i(s1), .slot2_i(s2),
    .rd_stb_o(rd_stb), .wr_stb_o(wr_stb), .reg_idx_o(idx_o), .wr_data_o(data_o)
  );

  typedef struct packed {
    logic        sec;
    logic [15:0] tag;
    logic [19:0] s1;
    logic [19:0] s2;
    logic        rd;
    logic        wr;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'hE000, 20'h12000, 20'hABCD0, 1'b0, 1'b1, 8'd2},  // R2 write
    '{1'b0, 16'hC000, 20'hA6000, 20'h11110, 1'b1, 1'b0, 8'd2},  // R2 read
    '{1'b0, 16'hC000, 20'h05000, 20'h22220, 1'b1, 1'b0, 8'd2},  // R2 tag decides read
    '{1'b0, 16'hE000, 20'h83000, 20'h33330, 1'b0, 1'b0, 8'd4},  // R4 malformed
    '{1'b0, 16'hA000, 20'h0F000, 20'h44440, 1'b0, 1'b0, 8'd3},  // R3 data tag only
    '{1'b0, 16'h8000, 20'h0E000, 20'h55550, 1'b0, 1'b0, 8'd3},  // R3 no tags
    '{1'b0, 16'h6000, 20'h0D000, 20'h66660, 1'b0, 1'b0, 8'd1},  // R1 frame invalid
    '{1'b0, 16'hE002, 20'h0C000, 20'h77770, 1'b0, 1'b0, 8'd7},  // R7 id 10
    '{1'b0, 16'hE003, 20'h0B000, 20'h78780, 1'b0, 1'b0, 8'd7},  // R7 id 11
    '{1'b0, 16'hE001, 20'h7F000, 20'h9ABC0, 1'b0, 1'b1, 8'd2},  // R2 id 01
    '{1'b0, 16'hFFF8, 20'h21000, 20'hBEEF0, 1'b0, 1'b1, 8'd2},  // R2 noise bits
    '{1'b1, 16'h8001, 20'h3C000, 20'h12340, 1'b0, 1'b1, 8'd5},  // R5 write
    '{1'b1, 16'h8001, 20'hBC000, 20'hFFFF0, 1'b1, 1'b0, 8'd5},  // R5 read
    '{1'b1, 16'hC001, 20'h15000, 20'h0F0F0, 1'b0, 1'b0, 8'd6},  // R6 addr tag
    '{1'b1, 16'hA001, 20'h16000, 20'h0E0E0, 1'b0, 1'b0, 8'd6},  // R6 data tag
    '{1'b1, 16'h8000, 20'h17000, 20'h0D0D0, 1'b0, 1'b0, 8'd7},  // R7 id 00
    '{1'b1, 16'h8003, 20'h18000, 20'h0C0C0, 1'b0, 1'b0, 8'd7},  // R7 id 11
    '{1'b1, 16'h0001, 20'h19000, 20'h0B0B0, 1'b0, 1'b0, 8'd1},  // R1 frame invalid
    '{1'b1, 16'h8001, 20'h0055F, 20'h5555F, 1'b0, 1'b1, 8'd8}   // R8 field bounds
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // R8 / R11 reference: capture fields on accepted frames only
  task automatic model(input logic rd, input logic wr,
                       input logic [19:0] a, input logic [19:0] d);
    if (rd || wr) m_idx = a[18:12];
    if (wr)       m_data = d[19:4];
  endtask

  task automatic check_out(input string req, input logic rd, input logic wr);
    chk(req, "rd_stb", 32'(rd_stb), 32'(rd));
    chk(req, "wr_stb", 32'(wr_stb), 32'(wr));
    chk(req, "reg_idx", 32'(idx_o), 32'(m_idx));     // R8 / R11
    chk(req, "wr_data", 32'(data_o), 32'(m_data));   // R8 / R11
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R10 reset state
    repeat (3) @(negedge clk);
    check_out("R10", 1'b0, 1'b0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      @(negedge clk);
      sec = VECS[i].sec; tag = VECS[i].tag; s1 = VECS[i].s1; s2 = VECS[i].s2;
      stb = 1'b1;
      @(negedge clk);
      stb = 1'b0;
      model(VECS[i].rd, VECS[i].wr, VECS[i].s1, VECS[i].s2);
      check_out($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].rd, VECS[i].wr);
      @(negedge clk);
      check_out("R9 pulse", 1'b0, 1'b0);  // R9 single cycle
    end

    // R9: valid content without frame strobe
    sec = 1'b0; tag = 16'hE000; s1 = 20'h44000; s2 = 20'hCAFE0;
    repeat (2) @(negedge clk);
    check_out("R9 no-stb", 1'b0, 1'b0);

    // R9: back-to-back frames, write then read
    @(negedge clk);
    tag = 16'hE000; s1 = 20'h51000; s2 = 20'h13570; stb = 1'b1;
    @(negedge clk);
    model(1'b0, 1'b1, s1, s2);
    check_out("R9 b2b-1", 1'b0, 1'b1);
    tag = 16'hC000; s1 = 20'hD2000; s2 = 20'h24680;
    @(negedge clk);
    stb = 1'b0;
    model(1'b1, 1'b0, s1, s2);
    check_out("R9 b2b-2 R11", 1'b1, 1'b0);
    @(negedge clk);
    check_out("R9 b2b-idle", 1'b0, 1'b0);

    // R10: reset in the middle of a run clears outputs
    tag = 16'hE000; s1 = 20'h6A000; s2 = 20'hFEDC0; stb = 1'b1;
    @(negedge clk);
    stb = 1'b0;
    model(1'b0, 1'b1, s1, s2);
    check_out("R8 pre-reset", 1'b0, 1'b1);
    rst_n = 1'b0;
    #1;
    m_idx = '0; m_data = '0;
    check_out("R10 mid-run", 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R10 after", 1'b0, 1'b0);

    finish_run();
  end
endmodule